// File: doc/BRIEF.md
# Configurable Serial Frame Engine

This block is an asynchronous serial transmitter and receiver sharing one line configuration and one bit-rate divisor. A clock divider makes a tick every `baud_div` clock cycles. Each serial bit lasts sixteen ticks. The 7-bit line configuration sets:

- the character length, from 5 to 8 bits;
- one or two stop bits;
- parity: none, odd, even, or a fixed (stick) value;
- a forced break on the transmit line.

Software-side logic writes bytes into a one-entry holding register. The transmitter moves each byte into its shift register and sends it LSB first. Two flags report progress. `tx_hold_empty` shows that the holding register can take another byte. `tx_idle` shows that both the holding register and the shifter are empty.

The receiver waits for a falling edge on the line. It confirms the start bit at mid-bit and samples every later bit at its centre. Each character is delivered with its own parity-error, framing-error and break flags. An overrun flag shows that a character replaced one that was never read.

Both directions use the same state sequence: IDLE → START → DATA → PARITY (only when parity is enabled) → STOP → IDLE.

Transmitter transitions:
- IDLE→START on a tick while the holding register is full.
- START→DATA after sixteen ticks.
- DATA→PARITY or DATA→STOP after the last data bit.
- PARITY→STOP after sixteen ticks.
- STOP→IDLE after one or two stop-bit times.

Receiver transitions:
- IDLE→START on a tick that sees the line fall.
- START→IDLE (false start) when the line is high again at the eighth tick.
- START→DATA when the line is still low at the eighth tick.
- DATA→PARITY or DATA→STOP after the last data sample.
- PARITY→STOP after the parity sample.
- STOP→IDLE after the stop-bit sample, which delivers the character.

Top module: `serial_frame_engine`

## Requirements
- R1: `line_cfg[1:0]` sets the character length: 0→5, 1→6, 2→7, 3→8 data bits. Data bits are sent and received LSB first. Received bytes are right-aligned and their unused upper bits read as zero.
- R2: `line_cfg[2]`=1 makes the transmitter send two stop bits (line high); 0 sends one. The receiver checks only the first stop bit.
- R3: Parity is controlled by three bits. `line_cfg[3]` enables a parity bit after the data. `line_cfg[4]`=1 selects even parity (data plus parity bit hold an even number of ones); 0 selects odd. When `line_cfg[5]`=1 the parity bit is fixed to the inverse of `line_cfg[4]`, both when sent and when checked.
- R4: While `line_cfg[6]`=1, `tx_line` is 0 in the same cycle, whatever the transmitter state.
- R5: Two flags report transmit progress. `tx_hold_empty` rises when the transmitter takes the byte from the holding register. `tx_idle` is 1 only when the holding register is empty and no frame is on the line. A write while the holding register is full is ignored.
- R6: The tick occurs once every `baud_div` clocks, and each bit lasts 16 ticks. With `baud_div`=0 there is no tick: a pending byte is not started and the line stays idle.
- R7: The receiver starts a frame on a high-to-low line transition. If the line is high again at the eighth tick, the frame is dropped as a false start.
- R8: Each delivered character carries two error flags. `rx_par_err` is set when parity is enabled and the received parity bit differs from the R3 value. `rx_frm_err` is set when the first stop bit is sampled low.
- R9: `rx_brk` is set for a character whose data bits, parity bit (if enabled) and first stop bit were all low. Such a character reads as data 0.
- R10: A delivery sets `rx_valid`. `rx_rd` clears `rx_valid` and `rx_overrun`. A delivery while `rx_valid` is still set (and not being read) sets `rx_overrun` and replaces the byte.
- R11: After reset, `tx_line`=1, `tx_hold_empty`=1, `tx_idle`=1 and `rx_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_cfg | input | 7 | Length, stop bits, parity enable, even select, stick parity, break |
| baud_div | input | DIV_W | Clocks per oversampling tick; 0 stops the tick |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_byte | input | 8 | Byte to transmit |
| tx_line | output | 1 | Serial output, idle high |
| tx_hold_empty | output | 1 | Holding register can accept a byte |
| tx_idle | output | 1 | Holding and shift registers both empty |
| rx_line | input | 1 | Serial input (asynchronous) |
| rx_rd | input | 1 | Consume the received character |
| rx_byte | output | 8 | Received character, right-aligned |
| rx_valid | output | 1 | Character available |
| rx_par_err | output | 1 | Parity error for this character |
| rx_frm_err | output | 1 | Framing error for this character |
| rx_brk | output | 1 | Break received |
| rx_overrun | output | 1 | Earlier character was lost |

## Verification
The bench sends transmit frames in five line settings:
- 8 bits with no parity;
- 5 bits with even parity;
- 7 bits with odd parity and two stop bits, sent back to back;
- two stick-parity settings with opposite fixed values.

Each of these separates one decode path: length, parity sense, stop-bit count or the fixed parity value. One frame uses a divisor of 3 to check bit timing.

Received frames cover:
- clean characters;
- forced parity faults in both normal and stick mode;
- a low stop bit;
- all-zero breaks with and without parity;
- a short low glitch;
- two characters left unread.

These separate framing errors from breaks, and false starts from real frames.

A zero divisor with a second write shows that stalled bytes are kept and extra writes are dropped.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
    localparam int OVS      = 16;
    localparam int OVS_W    = $clog2(OVS);
    localparam int CHAR_MAX = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } frame_st_e;

    function automatic logic [3:0] char_len(input logic [1:0] sel);
        return 4'd5 + {2'b00, sel};
    endfunction

    // Value of the parity bit for a masked character.
    function automatic logic par_bit(input logic [CHAR_MAX-1:0] d,
                                     input logic even_sel,
                                     input logic stick);
        if (stick) return ~even_sel;
        return even_sel ? ^d : ~^d;
    endfunction
endpackage

// File: rtl/sfe_baud.sv
module sfe_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic             div_on;
    logic             at_end;

    assign div_on = (divisor != '0);
    assign at_end = (cnt >= divisor - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (!div_on || at_end) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    assign tick = div_on && (cnt == divisor - 1'b1);
endmodule

// File: rtl/sfe_tx.sv
module sfe_tx
    import sfe_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [6:0]          cfg,
    input  logic                wr_en,
    input  logic [CHAR_MAX-1:0] wr_data,
    output logic                tx_out,
    output logic                hold_empty,
    output logic                tx_empty
);
    localparam logic [OVS_W-1:0] LAST = OVS_W'(OVS - 1);

    frame_st_e           state;
    logic [CHAR_MAX-1:0] hold_q;
    logic                hold_full;
    logic [CHAR_MAX-1:0] shreg;
    logic                pbit;
    logic [OVS_W-1:0]    sub_cnt;
    logic [3:0]          bit_cnt;
    logic [3:0]          nbits;
    logic [CHAR_MAX-1:0] masked;

    assign nbits  = char_len(cfg[1:0]);
    assign masked = hold_q & (8'hFF >> (4'd8 - nbits));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            hold_q    <= '0;
            hold_full <= 1'b0;
            shreg     <= '0;
            pbit      <= 1'b0;
            sub_cnt   <= '0;
            bit_cnt   <= '0;
        end else begin
            if (wr_en && !hold_full) begin
                hold_q    <= wr_data;
                hold_full <= 1'b1;
            end
            if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        if (hold_full) begin
                            shreg     <= masked;
                            pbit      <= par_bit(masked, cfg[4], cfg[5]);
                            hold_full <= 1'b0;
                            sub_cnt   <= '0;
                            state     <= ST_START;
                        end
                    end
                    ST_START: begin
                        sub_cnt <= sub_cnt + 1'b1;
                        if (sub_cnt == LAST) begin
                            bit_cnt <= '0;
                            state   <= ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        sub_cnt <= sub_cnt + 1'b1;
                        if (sub_cnt == LAST) begin
                            shreg   <= shreg >> 1;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == nbits - 4'd1) begin
                                bit_cnt <= '0;
                                state   <= cfg[3] ? ST_PARITY : ST_STOP;
                            end
                        end
                    end
                    ST_PARITY: begin
                        sub_cnt <= sub_cnt + 1'b1;
                        if (sub_cnt == LAST) state <= ST_STOP;
                    end
                    ST_STOP: begin
                        sub_cnt <= sub_cnt + 1'b1;
                        if (sub_cnt == LAST) begin
                            if (cfg[2] && bit_cnt == '0) bit_cnt <= 4'd1;
                            else                         state   <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_START:  tx_out = 1'b0;
            ST_DATA:   tx_out = shreg[0];
            ST_PARITY: tx_out = pbit;
            default:   tx_out = 1'b1;
        endcase
        if (cfg[6]) tx_out = 1'b0;
        hold_empty = !hold_full;
        tx_empty   = !hold_full && (state == ST_IDLE);
    end
endmodule

// File: rtl/sfe_rx.sv
module sfe_rx
    import sfe_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [1:0]          len_sel,
    input  logic                par_en,
    input  logic                par_even,
    input  logic                par_stick,
    input  logic                rx_in,
    input  logic                rd_en,
    output logic [CHAR_MAX-1:0] rx_data,
    output logic                rx_ready,
    output logic                par_err,
    output logic                frm_err,
    output logic                brk,
    output logic                overrun
);
    localparam logic [OVS_W-1:0] LAST = OVS_W'(OVS - 1);
    localparam logic [OVS_W-1:0] MID  = OVS_W'(OVS / 2 - 1);

    frame_st_e           state;
    logic                sync1, line;
    logic                line_prev;
    logic                pbit_rx;
    logic [OVS_W-1:0]    sub_cnt;
    logic [3:0]          bit_cnt;
    logic [CHAR_MAX-1:0] shreg;
    logic [3:0]          nbits;
    logic [CHAR_MAX-1:0] data_al;

    assign nbits   = char_len(len_sel);
    assign data_al = shreg >> (4'd8 - nbits);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            line  <= 1'b1;
        end else begin
            sync1 <= rx_in;
            line  <= sync1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            line_prev <= 1'b1;
            pbit_rx   <= 1'b0;
            sub_cnt   <= '0;
            bit_cnt   <= '0;
            shreg     <= '0;
            rx_data   <= '0;
            rx_ready  <= 1'b0;
            par_err   <= 1'b0;
            frm_err   <= 1'b0;
            brk       <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            if (rd_en) begin
                rx_ready <= 1'b0;
                overrun  <= 1'b0;
            end
            if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        line_prev <= line;
                        if (line_prev && !line) begin
                            sub_cnt <= '0;
                            state   <= ST_START;
                        end
                    end
                    ST_START: begin
                        sub_cnt <= sub_cnt + 1'b1;
                        if (sub_cnt == MID) begin
                            if (line) begin
                                line_prev <= 1'b1;
                                state     <= ST_IDLE;
                            end else begin
                                sub_cnt <= '0;
                                bit_cnt <= '0;
                                shreg   <= '0;
                                state   <= ST_DATA;
                            end
                        end
                    end
                    ST_DATA: begin
                        sub_cnt <= sub_cnt + 1'b1;
                        if (sub_cnt == LAST) begin
                            shreg   <= {line, shreg[CHAR_MAX-1:1]};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == nbits - 4'd1)
                                state <= par_en ? ST_PARITY : ST_STOP;
                        end
                    end
                    ST_PARITY: begin
                        sub_cnt <= sub_cnt + 1'b1;
                        if (sub_cnt == LAST) begin
                            pbit_rx <= line;
                            state   <= ST_STOP;
                        end
                    end
                    ST_STOP: begin
                        sub_cnt <= sub_cnt + 1'b1;
                        if (sub_cnt == LAST) begin
                            rx_data   <= data_al;
                            par_err   <= par_en && (pbit_rx != par_bit(data_al, par_even, par_stick));
                            frm_err   <= !line;
                            brk       <= !line && (data_al == '0) && (!par_en || !pbit_rx);
                            overrun   <= rx_ready && !rd_en;
                            rx_ready  <= 1'b1;
                            line_prev <= line;
                            state     <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/serial_frame_engine.sv
module serial_frame_engine
    import sfe_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [6:0]       line_cfg,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             tx_wr,
    input  logic [7:0]       tx_byte,
    output logic             tx_line,
    output logic             tx_hold_empty,
    output logic             tx_idle,
    input  logic             rx_line,
    input  logic             rx_rd,
    output logic [7:0]       rx_byte,
    output logic             rx_valid,
    output logic             rx_par_err,
    output logic             rx_frm_err,
    output logic             rx_brk,
    output logic             rx_overrun
);
    logic baud_tick;

    sfe_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (baud_div),
        .tick    (baud_tick)
    );

    sfe_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick),
        .cfg        (line_cfg),
        .wr_en      (tx_wr),
        .wr_data    (tx_byte),
        .tx_out     (tx_line),
        .hold_empty (tx_hold_empty),
        .tx_empty   (tx_idle)
    );

    sfe_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .len_sel   (line_cfg[1:0]),
        .par_en    (line_cfg[3]),
        .par_even  (line_cfg[4]),
        .par_stick (line_cfg[5]),
        .rx_in     (rx_line),
        .rd_en     (rx_rd),
        .rx_data   (rx_byte),
        .rx_ready  (rx_valid),
        .par_err   (rx_par_err),
        .frm_err   (rx_frm_err),
        .brk       (rx_brk),
        .overrun   (rx_overrun)
    );
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             brk_force,
    input logic [DIV_W-1:0] baud_div,
    input logic             baud_tick,
    input logic             tx_line,
    input logic             tx_hold_empty,
    input logic             tx_idle,
    input logic             rx_valid,
    input logic             rx_brk,
    input logic             rx_frm_err,
    input logic             rx_overrun
);
    p_break_space_r4: assert property (@(posedge clk) disable iff (!rst_n)
        brk_force |-> !tx_line);

    p_idle_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle && !brk_force) |-> tx_line);

    p_empty_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> tx_hold_empty);

    p_zero_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_div == '0) |-> !baud_tick);

    p_brk_frm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_brk) |-> rx_frm_err);

    p_overrun_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> $past(rx_valid));

    p_overrun_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> rx_valid);
endmodule

bind serial_frame_engine sfe_checker #(.DIV_W(DIV_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .brk_force     (line_cfg[6]),
    .baud_div      (baud_div),
    .baud_tick     (baud_tick),
    .tx_line       (tx_line),
    .tx_hold_empty (tx_hold_empty),
    .tx_idle       (tx_idle),
    .rx_valid      (rx_valid),
    .rx_brk        (rx_brk),
    .rx_frm_err    (rx_frm_err),
    .rx_overrun    (rx_overrun)
);

// File: tb/serial_frame_engine_tb_top.sv
module serial_frame_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  line_cfg = 7'h03;
    logic [15:0] baud_div = 16'd2;
    logic        tx_wr = 1'b0;
    logic [7:0]  tx_byte = 8'h00;
    logic        rx_line = 1'b1;
    logic        rx_rd = 1'b0;
    logic        tx_line, tx_hold_empty, tx_idle;
    logic [7:0]  rx_byte;
    logic        rx_valid, rx_par_err, rx_frm_err, rx_brk, rx_overrun;

    always #2 clk = ~clk;

    serial_frame_engine dut_i (
        .clk(clk), .rst_n(rst_n), .line_cfg(line_cfg), .baud_div(baud_div),
        .tx_wr(tx_wr), .tx_byte(tx_byte), .tx_line(tx_line),
        .tx_hold_empty(tx_hold_empty), .tx_idle(tx_idle),
        .rx_line(rx_line), .rx_rd(rx_rd), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
        .rx_brk(rx_brk), .rx_overrun(rx_overrun)
    );

    int checks = 0;
    int errors = 0;
    bit tx_mon_en = 1'b0;
    bit rx_mon_en = 1'b0;

    typedef struct { logic [7:0] d; logic [6:0] cfg; } tx_item_t;
    typedef struct { logic [7:0] d; logic pe; logic fe; logic bk; logic ov; } rx_item_t;
    tx_item_t txq[$];
    rx_item_t rxq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic int nb_of(input logic [6:0] c);
        return 5 + int'(c[1:0]);
    endfunction

    function automatic logic [7:0] mask_of(input logic [6:0] c);
        return 8'hFF >> (8 - nb_of(c));
    endfunction

    function automatic logic ref_par(input logic [7:0] d, input logic [6:0] c);
        if (c[5]) return ~c[4];
        return c[4] ? ^d : ~^d;
    endfunction

    // ---------------- transmit driver and monitor ----------------
    task automatic send_tx(input logic [7:0] d);
        tx_item_t it;
        wait (tx_hold_empty == 1'b1);
        @(posedge clk); #1;
        it.d = d & mask_of(line_cfg);
        it.cfg = line_cfg;
        txq.push_back(it);
        tx_wr = 1'b1; tx_byte = d;
        tk(1);
        tx_wr = 1'b0;
    endtask

    task automatic wait_tx;
        wait (txq.size() == 0);
        @(posedge clk);
        wait (tx_idle == 1'b1);
        tk(32 * int'(baud_div));
    endtask

    initial forever begin
        @(negedge clk);
        if (tx_mon_en && rst_n && !tx_line && !line_cfg[6]) begin
            int bp;
            int nb;
            tx_item_t it;
            logic [7:0] got;
            logic pe;
            bp = 16 * int'(baud_div);
            got = '0;
            repeat (bp / 2) @(negedge clk);
            chk(tx_line == 1'b0, "R6", "tx start bit at mid", tx_line, 0);
            if (txq.size() == 0) begin
                chk(1'b0, "R5", "unexpected tx frame", 1, 0);
            end else begin
                it = txq.pop_front();
                nb = nb_of(it.cfg);
                for (int i = 0; i < nb; i++) begin
                    repeat (bp) @(negedge clk);
                    got[i] = tx_line;
                end
                chk(got == it.d, "R1", "tx data bits", got, it.d);
                if (it.cfg[3]) begin
                    repeat (bp) @(negedge clk);
                    pe = ref_par(it.d, it.cfg);
                    chk(tx_line == pe, "R3", "tx parity bit", tx_line, pe);
                end
                repeat (bp) @(negedge clk);
                chk(tx_line == 1'b1, "R2", "tx first stop bit", tx_line, 1);
                if (it.cfg[2]) begin
                    repeat (bp) @(negedge clk);
                    chk(tx_line == 1'b1, "R2", "tx second stop bit", tx_line, 1);
                end
            end
        end
    end

    // ---------------- receive driver and monitor ----------------
    task automatic rx_frame(input logic [7:0] d, input bit bad_par,
                            input bit stop_v, input bit exp_ov, input bit push);
        int bp;
        int nb;
        logic [7:0] dm;
        logic pb;
        rx_item_t it;
        bp = 16 * int'(baud_div);
        nb = nb_of(line_cfg);
        dm = d & mask_of(line_cfg);
        pb = ref_par(dm, line_cfg) ^ bad_par;
        it.d  = stop_v ? dm : dm;
        it.pe = line_cfg[3] && bad_par;
        it.fe = !stop_v;
        it.bk = !stop_v && (dm == 8'h00) && (!line_cfg[3] || !pb);
        it.ov = exp_ov;
        if (push) rxq.push_back(it);
        rx_line = 1'b0; tk(bp);
        for (int i = 0; i < nb; i++) begin
            rx_line = dm[i]; tk(bp);
        end
        if (line_cfg[3]) begin
            rx_line = pb; tk(bp);
        end
        rx_line = stop_v; tk(bp);
        if (line_cfg[2]) begin
            rx_line = 1'b1; tk(bp);
        end
        rx_line = 1'b1;
        tk(2 * bp);
    endtask

    initial forever begin
        @(negedge clk);
        if (rx_mon_en && rx_valid) begin
            rx_item_t it;
            if (rxq.size() == 0) begin
                chk(1'b0, "R7", "unexpected rx character", rx_byte, 0);
            end else begin
                it = rxq.pop_front();
                chk(rx_byte == it.d, "R1", "rx data", rx_byte, it.d);
                chk(rx_par_err == it.pe, "R8", "rx parity error flag", rx_par_err, it.pe);
                chk(rx_frm_err == it.fe, "R8", "rx framing error flag", rx_frm_err, it.fe);
                chk(rx_brk == it.bk, "R9", "rx break flag", rx_brk, it.bk);
                chk(rx_overrun == it.ov, "R10", "rx overrun flag", rx_overrun, it.ov);
            end
            @(posedge clk); #1;
            rx_rd = 1'b1;
            @(posedge clk); #1;
            rx_rd = 1'b0;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        tk(5);
        rst_n = 1'b1;
        tk(2);
        @(negedge clk);
        chk(tx_line == 1'b1, "R11", "reset tx_line", tx_line, 1);
        chk(tx_hold_empty == 1'b1, "R11", "reset hold empty", tx_hold_empty, 1);
        chk(tx_idle == 1'b1, "R11", "reset tx idle", tx_idle, 1);
        chk(rx_valid == 1'b0, "R11", "reset rx_valid", rx_valid, 0);
        tk(1);
        tx_mon_en = 1'b1;
        rx_mon_en = 1'b1;

        // R5: hold empties before the frame ends
        line_cfg = 7'h03;
        send_tx(8'hA5);
        tk(40);
        @(negedge clk);
        chk(tx_hold_empty == 1'b1, "R5", "hold empty during frame", tx_hold_empty, 1);
        chk(tx_idle == 1'b0, "R5", "tx not idle during frame", tx_idle, 0);
        wait_tx();

        line_cfg = 7'h18;            // R3 5 bits even parity
        send_tx(8'h13); send_tx(8'h1C);
        wait_tx();
        line_cfg = 7'h0E;            // R2 7 bits odd parity two stops
        send_tx(8'h5A); send_tx(8'h21);
        wait_tx();
        line_cfg = 7'h39;            // R3 stick, fixed 0
        send_tx(8'h2F);
        wait_tx();
        line_cfg = 7'h2B;            // R3 stick, fixed 1
        send_tx(8'h00);
        wait_tx();
        line_cfg = 7'h03;
        baud_div = 16'd3;            // R6 other divisor
        send_tx(8'hC3);
        wait_tx();
        baud_div = 16'd2;

        // R4 break forcing
        line_cfg = 7'h43;
        @(negedge clk);
        chk(tx_line == 1'b0, "R4", "break forces space", tx_line, 0);
        tk(1);
        line_cfg = 7'h03;
        @(negedge clk);
        chk(tx_line == 1'b1, "R4", "break release", tx_line, 1);
        tk(1);

        // R6 zero divisor stalls, R5 write while full ignored
        baud_div = 16'd0;
        send_tx(8'h77);
        tk(200);
        @(negedge clk);
        chk(tx_line == 1'b1, "R6", "no frame with zero divisor", tx_line, 1);
        chk(tx_hold_empty == 1'b0, "R6", "byte held with zero divisor", tx_hold_empty, 0);
        tk(1);
        tx_wr = 1'b1; tx_byte = 8'h88;
        tk(1);
        tx_wr = 1'b0;
        baud_div = 16'd2;
        wait_tx();
        chk(txq.size() == 0, "R5", "tx queue drained", txq.size(), 0);
        @(negedge clk);
        chk(tx_idle && tx_hold_empty, "R5", "idle after single frame", tx_idle, 1);
        tk(1);

        // receive side
        line_cfg = 7'h03;
        rx_frame(8'h55, 0, 1, 0, 1);
        rx_frame(8'hA3, 0, 1, 0, 1);
        line_cfg = 7'h1A;            // R8 7 bits even parity
        rx_frame(8'h3C, 1, 1, 0, 1);
        rx_frame(8'h41, 0, 1, 0, 1);
        line_cfg = 7'h38;            // R3 5 bits stick
        rx_frame(8'h15, 0, 1, 0, 1);
        rx_frame(8'h0A, 1, 1, 0, 1);
        line_cfg = 7'h0D;            // R2 6 bits odd two stops
        rx_frame(8'h2A, 0, 1, 0, 1);
        line_cfg = 7'h03;
        rx_frame(8'h66, 0, 0, 0, 1); // R8 framing error
        rx_frame(8'h00, 0, 0, 0, 1); // R9 break
        line_cfg = 7'h1B;
        rx_frame(8'h00, 0, 0, 0, 1); // R9 break with parity
        line_cfg = 7'h03;

        // R7 false start
        rx_line = 1'b0; tk(8);
        rx_line = 1'b1; tk(64);
        @(negedge clk);
        chk(rx_valid == 1'b0, "R7", "glitch not delivered", rx_valid, 0);
        tk(1);

        // R10 overrun
        wait (rxq.size() == 0);
        tk(4);
        rx_mon_en = 1'b0;
        rx_frame(8'h11, 0, 1, 0, 0);
        rx_frame(8'h22, 0, 1, 1, 1);
        @(negedge clk);
        chk(rx_valid == 1'b1, "R10", "unread character pending", rx_valid, 1);
        chk(rx_byte == 8'h22, "R10", "newer byte replaces older", rx_byte, 8'h22);
        tk(1);
        rx_mon_en = 1'b1;
        wait (rxq.size() == 0);
        tk(4);
        @(negedge clk);
        chk(rx_valid == 1'b0, "R10", "read clears valid", rx_valid, 0);
        chk(rx_overrun == 1'b0, "R10", "read clears overrun", rx_overrun, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule